// File: doc/BRIEF.md
# Indirect Shared Register Access Bridge

This bridge gives a host a path into a bank of internal shared registers using only two host-visible words: a command word and a data word. The host puts a 16-bit register offset and a 2-bit operation code into the command word. An operation code that names a read or a write launches exactly one transaction on a simple request/acknowledge internal register bus. Read results come back to the host through the data word. Write data is taken from the data word, which the host loads before it issues the command.

The bridge holds all of its state locally and needs nothing from the main internal processor. A transfer can therefore run while that processor is unpowered or has not been granted access. A busy flag in the command word tells the host when the internal bus has acknowledged. While that flag is set, the bridge ignores further command writes and data writes, so an access in flight cannot be corrupted. Host reads have no side effects. The read port is combinational and selects between the two words.

Top module: `shreg_bridge`

## Requirements
- R1: After synchronous active-low reset, the command word reads 0, the data word reads 0 and `ib_req` is low.
- R2: A command write accepted while idle stores host_wdata[15:0] as the offset and host_wdata[29:28] as the operation code. Both read back at the same bit positions of the command word.
- R3: Operation code 3 in an accepted command write raises `ib_req` with `ib_we` high on the next cycle. The bus carries the stored offset and the current data word.
- R4: Operation code 2 in an accepted command write raises `ib_req` with `ib_we` low on the next cycle. On acknowledge, `ib_rdata` is captured into the data word.
- R5: Operation codes 0 and 1 start no bus transaction. They only update the stored offset and code.
- R6: Command bit 31 is the busy flag. It is set from the cycle after a launch until the cycle after `ib_ack`, and it always equals `ib_req`.
- R7: A command write while busy is ignored. The offset, the code and the number of transactions are unchanged.
- R8: A data write while busy is ignored. After a read completes, the data word holds the captured value until the next completed read or the next host data write.
- R9: While `ib_req` is high and not yet acknowledged, `ib_req`, `ib_we`, `ib_offset` and `ib_wdata` stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_sel | input | 1 | Word select: 0 = command word, 1 = data word |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Selected word, combinational |
| ib_req | output | 1 | Internal bus request, held until acknowledged |
| ib_we | output | 1 | 1 = write transaction, 0 = read transaction |
| ib_offset | output | 16 | Internal register offset |
| ib_wdata | output | 32 | Internal write data |
| ib_rdata | input | 32 | Internal read data, valid with ib_ack |
| ib_ack | input | 1 | One-cycle acknowledge of the pending request |

## Verification
Suppose the busy state is wrong. A request that never clears shows up as a busy bit that stays set. A request that clears too early shows up as a read returning the previous data word on the first host read after the transfer. A lost write shows up on the next read of the same offset. The bench therefore reads back every transfer through the bridge against a reference copy of the bank, using random acknowledge latencies. The bench also counts bus transactions, so that a spurious launch from codes 0 or 1, or from a trigger while busy, appears as a count off by one within a few cycles.

// File: rtl/shb_pkg.sv
// Shared types for the indirect shared register bridge.
// Assumes a 2-bit operation code field in the command word.
package shb_pkg;
    typedef enum logic [1:0] {
        OP_NONE0 = 2'd0,
        OP_NONE1 = 2'd1,
        OP_READ  = 2'd2,
        OP_WRITE = 2'd3
    } op_code_e;

    localparam int OP_W = 2;

    // Returns 1 when the code launches a bus transaction.
    function automatic logic op_launches(input logic [OP_W-1:0] c);
        return (c == OP_READ) || (c == OP_WRITE);
    endfunction
endpackage

// File: rtl/shb_dec.sv
// Host write decoder: decides which host writes are accepted and whether
// a command write launches a bus transaction.
// Assumes host_wr is a single-cycle strobe and busy comes from the sequencer.
module shb_dec
    import shb_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int CODE_LSB = 28
) (
    input  logic              host_wr,
    input  logic              host_sel,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              busy,
    output logic              cmd_we,
    output logic              data_we,
    output logic              launch,
    output logic              launch_write
);
    logic [OP_W-1:0] op_field;

    // Split the strobe into command and data writes, gated by busy.
    always_comb begin
        op_field     = host_wdata[CODE_LSB +: OP_W];
        cmd_we       = host_wr && !host_sel && !busy;
        data_we      = host_wr &&  host_sel && !busy;
        launch       = cmd_we && op_launches(op_field);
        launch_write = (op_field == OP_WRITE);
    end
endmodule

// File: rtl/shb_regs.sv
// Storage for the offset, the operation code and the data word.
// Assumes cap_en (read capture) and data_we are never both set, because
// data writes are blocked while a transaction is in flight.
module shb_regs
    import shb_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int OFF_W    = 16,
    parameter int CODE_LSB = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic              data_we,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] cap_data,
    output logic [OFF_W-1:0]  offset_q,
    output logic [OP_W-1:0]   code_q,
    output logic [DATA_W-1:0] data_q
);
    // Offset and code latch on an accepted command write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            offset_q <= '0;
            code_q   <= '0;
        end else if (cmd_we) begin
            offset_q <= host_wdata[OFF_W-1:0];
            code_q   <= host_wdata[CODE_LSB +: OP_W];
        end
    end

    // Data word loads from read capture or from an accepted host write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (cap_en) begin
            data_q <= cap_data;
        end else if (data_we) begin
            data_q <= host_wdata;
        end
    end
endmodule

// File: rtl/shb_seq.sv
// Request sequencer: holds one internal bus request from launch until ack.
// Assumes the target acknowledges with a one-cycle ib_ack pulse.
module shb_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    input  logic launch_write,
    input  logic ib_ack,
    output logic req_q,
    output logic we_q,
    output logic cap_en
);
    // Raise the request on launch, drop it on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
            we_q  <= 1'b0;
        end else if (!req_q && launch) begin
            req_q <= 1'b1;
            we_q  <= launch_write;
        end else if (req_q && ib_ack) begin
            req_q <= 1'b0;
        end
    end

    // Read data is captured on the acknowledge of a read request.
    always_comb cap_en = req_q && ib_ack && !we_q;
endmodule

// File: rtl/shreg_bridge.sv
// Top of the indirect shared register bridge. A host command word carries
// the offset, the operation code and the busy flag; a host data word holds
// write data or read results. Assumes one outstanding internal transaction.
module shreg_bridge
    import shb_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int OFF_W    = 16,
    parameter int CODE_LSB = 28,
    parameter int BUSY_BIT = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_sel,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              ib_req,
    output logic              ib_we,
    output logic [OFF_W-1:0]  ib_offset,
    output logic [DATA_W-1:0] ib_wdata,
    input  logic [DATA_W-1:0] ib_rdata,
    input  logic              ib_ack
);
    logic              cmd_we, data_we, launch, launch_write, cap_en, busy;
    logic [OFF_W-1:0]  offset_q;
    logic [OP_W-1:0]   code_q;
    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] cmd_view;

    shb_dec #(.DATA_W(DATA_W), .CODE_LSB(CODE_LSB)) u_dec (
        .host_wr(host_wr), .host_sel(host_sel), .host_wdata(host_wdata),
        .busy(busy), .cmd_we(cmd_we), .data_we(data_we),
        .launch(launch), .launch_write(launch_write)
    );

    shb_regs #(.DATA_W(DATA_W), .OFF_W(OFF_W), .CODE_LSB(CODE_LSB)) u_regs (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .data_we(data_we),
        .host_wdata(host_wdata), .cap_en(cap_en), .cap_data(ib_rdata),
        .offset_q(offset_q), .code_q(code_q), .data_q(data_q)
    );

    shb_seq u_seq (
        .clk(clk), .rst_n(rst_n), .launch(launch), .launch_write(launch_write),
        .ib_ack(ib_ack), .req_q(busy), .we_q(ib_we), .cap_en(cap_en)
    );

    // Assemble the command word view from its fields.
    always_comb begin
        cmd_view                      = '0;
        cmd_view[OFF_W-1:0]           = offset_q;
        cmd_view[CODE_LSB +: OP_W]    = code_q;
        cmd_view[BUSY_BIT]            = busy;
    end

    // Host read mux and internal bus drive.
    always_comb begin
        host_rdata = host_sel ? data_q : cmd_view;
        ib_req     = busy;
        ib_offset  = offset_q;
        ib_wdata   = data_q;
    end
endmodule

// File: rtl/shreg_bridge_chk.sv
// Protocol checker for shreg_bridge, attached by bind.
// Assumes the default field layout (code at 29:28, busy at 31).
module shreg_bridge_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        host_wr,
    input logic        host_sel,
    input logic [31:0] host_wdata,
    input logic [31:0] host_rdata,
    input logic        ib_req,
    input logic        ib_we,
    input logic [15:0] ib_offset,
    input logic [31:0] ib_wdata,
    input logic [31:0] ib_rdata,
    input logic        ib_ack
);
    assert_write_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !host_sel && !ib_req && host_wdata[29:28] == 2'd3)
        |=> (ib_req && ib_we && ib_offset == $past(host_wdata[15:0])));

    assert_read_launch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !host_sel && !ib_req && host_wdata[29:28] == 2'd2)
        |=> (ib_req && !ib_we));

    assert_no_launch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ib_req && !(host_wr && !host_sel && host_wdata[29])) |=> !ib_req);

    assert_busy_mirror_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !host_sel |-> (host_rdata[31] == ib_req));

    assert_drop_on_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ib_req && ib_ack) |=> !ib_req);

    assert_busy_cmd_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ib_req && !ib_ack && host_wr && !host_sel) |=> $stable(ib_offset));

    assert_read_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ib_req && ib_ack && !ib_we)
        |=> (!host_sel || host_rdata == $past(ib_rdata)));

    assert_req_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ib_req && !ib_ack) |=> (ib_req && $stable(ib_we) &&
            $stable(ib_offset) && $stable(ib_wdata)));
endmodule

bind shreg_bridge shreg_bridge_chk u_chk (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .ib_req(ib_req),
    .ib_we(ib_we), .ib_offset(ib_offset), .ib_wdata(ib_wdata),
    .ib_rdata(ib_rdata), .ib_ack(ib_ack)
);

// File: tb/sim_shreg_bridge.sv
module sim_shreg_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_sel = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        ib_req, ib_we;
    logic [15:0] ib_offset;
    logic [31:0] ib_wdata;
    logic [31:0] ib_rdata = '0;
    logic        ib_ack = 1'b0;

    int errors = 0;
    int checks = 0;
    int txn_cnt = 0;
    int force_lat = -1;
    logic [15:0] last_woff;
    logic [31:0] last_wdat;
    logic [31:0] bank [16];
    logic [31:0] ref_bank [16];

    always #10 clk = ~clk;

    shreg_bridge u0 (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .ib_req(ib_req),
        .ib_we(ib_we), .ib_offset(ib_offset), .ib_wdata(ib_wdata),
        .ib_rdata(ib_rdata), .ib_ack(ib_ack)
    );

    function automatic logic [31:0] init_val(input int i);
        return 32'hA500_0000 | (i * 32'h111);
    endfunction

    function automatic logic [31:0] cmd_word(input logic busy, input logic [1:0] code,
                                             input logic [15:0] off);
        return {busy, 1'b0, code, 12'h000, off};
    endfunction

    // Internal register bank with variable acknowledge latency.
    initial begin
        int cnt;
        logic serving;
        serving = 1'b0;
        cnt = 0;
        for (int i = 0; i < 16; i++) bank[i] = init_val(i);
        forever begin
            @(negedge clk);
            if (ib_ack) begin
                ib_ack = 1'b0;
            end else if (ib_req) begin
                if (!serving) begin
                    serving = 1'b1;
                    cnt = (force_lat >= 0) ? force_lat : int'($urandom % 5);
                end
                if (cnt == 0) begin
                    serving = 1'b0;
                    ib_ack = 1'b1;
                    txn_cnt++;
                    if (ib_we) begin
                        bank[ib_offset[3:0]] = ib_wdata;
                        last_woff = ib_offset;
                        last_wdat = ib_wdata;
                    end else begin
                        ib_rdata = bank[ib_offset[3:0]];
                    end
                end else begin
                    cnt--;
                end
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic sel, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_sel = sel; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(input logic sel, output logic [31:0] d);
        host_sel = sel;
        #1;
        d = host_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] w;
        for (int k = 0; k < 100; k++) begin
            host_read(1'b0, w);
            if (!w[31]) return;
            @(negedge clk);
        end
    endtask

    task automatic do_write(input logic [15:0] off, input logic [31:0] d);
        host_write(1'b1, d);
        host_write(1'b0, cmd_word(1'b0, 2'd3, off));
        wait_idle();
        ref_bank[off[3:0]] = d;
    endtask

    task automatic do_read(input logic [15:0] off, output logic [31:0] d);
        host_write(1'b0, cmd_word(1'b0, 2'd2, off));
        wait_idle();
        host_read(1'b1, d);
    endtask

    initial begin
        logic [31:0] r;
        int t0;
        void'($urandom(32'd1234));
        for (int i = 0; i < 16; i++) ref_bank[i] = init_val(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        host_read(1'b0, r); check("R1 cmd", r, 32'h0);
        host_read(1'b1, r); check("R1 data", r, 32'h0);
        check("R1 req", {31'h0, ib_req}, 32'h0);

        // R2, R5: code 0 and code 1 only store the offset
        t0 = txn_cnt;
        host_write(1'b0, cmd_word(1'b0, 2'd0, 16'h1234));
        host_read(1'b0, r); check("R2 offset code0", r, cmd_word(1'b0, 2'd0, 16'h1234));
        host_write(1'b0, cmd_word(1'b0, 2'd1, 16'hBEEF));
        host_read(1'b0, r); check("R2 offset code1", r, cmd_word(1'b0, 2'd1, 16'hBEEF));
        repeat (6) @(negedge clk);
        check("R5 no txn", txn_cnt, t0);

        // R3: directed write, then R6 busy set right after trigger
        force_lat = 3;
        host_write(1'b1, 32'hCAFE_0005);
        host_write(1'b0, cmd_word(1'b0, 2'd3, 16'h0005));
        host_read(1'b0, r); check("R6 busy set", r, cmd_word(1'b1, 2'd3, 16'h0005));
        wait_idle();
        ref_bank[5] = 32'hCAFE_0005;
        host_read(1'b0, r); check("R6 busy clear", r, cmd_word(1'b0, 2'd3, 16'h0005));
        check("R3 bus offset", {16'h0, last_woff}, 32'h0005);
        check("R3 bus data", last_wdat, 32'hCAFE_0005);

        // R4: read back
        do_read(16'h0005, r); check("R4 readback", r, 32'hCAFE_0005);

        // R7, R8: command and data writes while busy are ignored
        force_lat = 8;
        t0 = txn_cnt;
        host_write(1'b0, cmd_word(1'b0, 2'd2, 16'h0009));
        host_write(1'b0, cmd_word(1'b0, 2'd3, 16'h0002));
        host_write(1'b1, 32'hDEAD_BEEF);
        host_read(1'b0, r); check("R7 cmd while busy", r, cmd_word(1'b1, 2'd2, 16'h0009));
        wait_idle();
        repeat (4) @(negedge clk);
        check("R7 one txn", txn_cnt, t0 + 1);
        host_read(1'b1, r); check("R8 data while busy", r, init_val(9));
        repeat (5) @(negedge clk);
        host_read(1'b1, r); check("R8 data held", r, init_val(9));
        check("R7 bank untouched", bank[2], init_val(2));

        // R4: zero-latency acknowledge corner
        force_lat = 0;
        do_read(16'h000C, r); check("R4 fast ack", r, init_val(12));

        // R3, R4, R8: random mixed traffic against reference bank
        force_lat = -1;
        for (int n = 0; n < 80; n++) begin
            logic [15:0] off;
            logic [31:0] d;
            int op;
            off = 16'($urandom);
            op = int'($urandom % 4);
            if (op == 0) begin
                d = $urandom;
                do_write(off, d);
            end else if (op == 1) begin
                t0 = txn_cnt;
                host_write(1'b0, cmd_word(1'b0, 2'($urandom % 2), off));
                repeat (3) @(negedge clk);
                check("R5 random no txn", txn_cnt, t0);
            end else begin
                do_read(off, d);
                check("R4 random read", d, ref_bank[off[3:0]]);
            end
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog
    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule